// File: doc/BRIEF.md
# Signed-Count Shift and Rotate Unit

This unit is a datapath element that moves a 32-bit operand left or right by a distance taken from a signed 12-bit count. The count is a two's-complement number. Its sign selects the direction, and its magnitude selects how many bit positions to move. A select input chooses between a logical shift and a rotate.

A shift is done by a combinational shifter and is registered on the clock edge that accepts the start strobe. A rotate is done iteratively, one bit position per clock. While a rotate is in progress the unit is busy, and any further start strobe is dropped. The 33-bit result register holds the last bit pushed out by a left shift in its top bit. A one-cycle done pulse marks each completed operation, and the result register keeps its value until the next operation completes.

Top module: `shift_rotate_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, result is 0 and done is 0.
- R2: The count is a 12-bit two's-complement value. A count of zero or more moves right by the count. A negative count moves left by the count's magnitude.
- R3: With rotate=0 the operation is a logical shift: vacated bits fill with zeros and result[31:0] is the shifted operand. On a left shift result[32] is the last bit pushed out of bit 31. On a right shift result[32] is 0. A count of 0 gives {0, operand}.
- R4: A shift whose start is sampled at edge E0 updates result and raises done at E0, so both are visible in the cycle that follows.
- R5: With rotate=1 each step of a right rotate moves bit 0 into bit 31, and each step of a left rotate moves bit 31 into bit 0. result[32] is 0 after any rotate.
- R6: A rotate of magnitude m whose start is sampled at edge E0 raises done, with the final value, at edge E0+m. A rotate with count 0 therefore finishes at E0, the same as a shift, with result {0, operand}.
- R7: A start strobe sampled while a rotate is in progress is ignored. It does not change the result, the completion time, or done.
- R8: A count magnitude greater than 16 acts as a magnitude of 16, in the direction given by the count's sign.
- R9: done is high for exactly one cycle per accepted operation. result holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; accepted only when the unit is idle |
| rotate | input | 1 | Operation select: 0 = logical shift, 1 = rotate |
| count | input | 12 | Signed distance: sign sets the direction, magnitude sets the distance |
| operand | input | 32 | Value to shift or rotate, sampled with start |
| result | output | 33 | Registered result; bit 32 holds the last bit pushed out on a left shift |
| done | output | 1 | One-cycle pulse when result is updated |

## Verification
Shift results, and rotates with a zero count, are due with done in the cycle just after the accepting edge. A rotate of magnitude m is due m edges after that, and saturated counts use m = 16. The bench model advances on the same rising edges as the design, using only the port inputs, and keeps an expected result, an expected done, and a remaining-cycle count for a pending rotate. Both outputs are compared against the model at every falling edge, so every cycle, including idle cycles, busy cycles and cycles with an ignored start, is checked at the exact cycle the value is due.

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit #(
  parameter int WIDTH     = 32,
  parameter int CNT_W     = 12,
  parameter int MAX_SHIFT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rotate,
  input  logic [CNT_W-1:0] count,
  input  logic [WIDTH-1:0] operand,
  output logic [WIDTH:0]   result,
  output logic             done
);

  localparam int MAG_W = $clog2(MAX_SHIFT + 1);

  logic             busy;
  logic             dir_left;
  logic [MAG_W-1:0] rem;
  logic [WIDTH-1:0] work;

  logic             go_left;
  logic [CNT_W-1:0] mag_raw;
  logic [MAG_W-1:0] mag;
  logic [WIDTH:0]   wide;
  logic [WIDTH:0]   shifted;
  logic [WIDTH-1:0] stepped;
  logic             accept;

  assign go_left = count[CNT_W-1];
  assign mag_raw = go_left ? (~count + 1'b1) : count;
  assign mag     = (mag_raw > CNT_W'(MAX_SHIFT)) ? MAG_W'(MAX_SHIFT) : mag_raw[MAG_W-1:0];
  assign wide    = {1'b0, operand};
  assign shifted = go_left ? (wide << mag) : (wide >> mag);
  assign stepped = dir_left ? {work[WIDTH-2:0], work[WIDTH-1]}
                            : {work[0], work[WIDTH-1:1]};
  assign accept  = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      done     <= 1'b0;
      busy     <= 1'b0;
      dir_left <= 1'b0;
      rem      <= '0;
      work     <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (!rotate || mag == '0) begin
          result <= shifted;
          done   <= 1'b1;
        end else begin
          work     <= operand;
          rem      <= mag;
          dir_left <= go_left;
          busy     <= 1'b1;
        end
      end else if (busy) begin
        work <= stepped;
        rem  <= rem - 1'b1;
        if (rem == MAG_W'(1)) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= {1'b0, stepped};
        end
      end
    end
  end

endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk #(
  parameter int WIDTH = 32,
  parameter int MAG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             rotate,
  input logic [WIDTH:0]   result,
  input logic             done,
  input logic             busy,
  input logic [MAG_W-1:0] rem,
  input logic [WIDTH-1:0] work
);

  // R4
  shift_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !rotate |=> done);

  // R5
  rotate_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(busy) |-> !result[WIDTH] &&
      ($countones(result[WIDTH-1:0]) == $countones($past(work))));

  // R7
  busy_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rem != MAG_W'(1) |=> busy && rem == $past(rem) - 1'b1);

  // R9
  done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start) || $past(busy));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(.WIDTH(WIDTH), .MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rotate(rotate),
  .result(result), .done(done), .busy(busy), .rem(rem), .work(work)
);

// File: tb/test_shift_rotate_unit.sv
module test_shift_rotate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rotate = 1'b0;
  logic [11:0] count = '0;
  logic [31:0] operand = '0;
  logic [32:0] result;
  logic        done;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_tag = "R1";
  string done_tag = "R1";

  logic [32:0] m_res = '0;
  logic        m_done = 1'b0;
  logic [32:0] m_pend = '0;
  int          m_cnt = 0;
  bit          m_busy = 0;

  shift_rotate_unit i_shift_rotate_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .rotate(rotate),
    .count(count), .operand(operand), .result(result), .done(done)
  );

  always #10 clk = ~clk;

  function automatic int magnitude(input logic [11:0] c);
    int v;
    v = $signed(c);
    if (v < 0) v = -v;
    if (v > 16) v = 16;
    return v;
  endfunction

  function automatic logic [32:0] ref_op(input bit rot, input logic [11:0] c, input logic [31:0] x);
    logic [32:0] r;
    logic [31:0] w;
    int m;
    m = magnitude(c);
    r = {1'b0, x};
    w = x;
    for (int k = 0; k < m; k++) begin
      if (rot) w = c[11] ? {w[30:0], w[31]} : {w[0], w[31:1]};
      else     r = c[11] ? (r << 1) : (r >> 1);
    end
    return rot ? {1'b0, w} : r;
  endfunction

  always @(posedge clk) begin
    m_done <= 1'b0;
    if (!rst_n) begin
      m_res  <= '0;
      m_busy <= 0;
      m_cnt  <= 0;
    end else if (start && !m_busy) begin
      if (!rotate || magnitude(count) == 0) begin
        m_res  <= ref_op(rotate, count, operand);
        m_done <= 1'b1;
      end else begin
        m_pend <= ref_op(1'b1, count, operand);
        m_cnt  <= magnitude(count);
        m_busy <= 1;
      end
    end else if (m_busy) begin
      m_cnt <= m_cnt - 1;
      if (m_cnt == 1) begin
        m_res  <= m_pend;
        m_done <= 1'b1;
        m_busy <= 0;
      end
    end
  end

  always @(negedge clk) begin
    n_checks++;
    if (result !== m_res) begin
      n_fail++;
      $display("FAIL %s result: actual %h expected %h at %0t", cur_tag, result, m_res, $time);
    end
    n_checks++;
    if (done !== m_done) begin
      n_fail++;
      $display("FAIL %s done: actual %b expected %b at %0t", done_tag, done, m_done, $time);
    end
  end

  task automatic drive(input bit s, input bit rot, input logic [11:0] c, input logic [31:0] x);
    @(negedge clk);
    #1;
    start = s; rotate = rot; count = c; operand = x;
  endtask

  task automatic run_op(input bit rot, input logic [11:0] c, input logic [31:0] x,
                        input string rtag, input string dtag);
    cur_tag = rtag;
    done_tag = dtag;
    drive(1, rot, c, x);
    drive(0, 0, 12'h000, 32'h0);
    repeat (magnitude(c) + 2) drive(0, 0, 12'h000, 32'h0);
    cur_tag = "R9";
    done_tag = "R9";
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4: shifts right and left, count zero
    run_op(0, 12'd0,    32'hDEADBEEF, "R3", "R4");
    run_op(0, 12'd1,    32'h80000001, "R3", "R4");
    run_op(0, 12'd5,    32'hF0F0F0F0, "R3", "R4");
    run_op(0, 12'd16,   32'h12345678, "R3", "R4");
    // R2: negative count moves left, bit 32 captures shift-out
    run_op(0, -12'sd1,  32'h80000000, "R2", "R4");
    run_op(0, -12'sd4,  32'h9ABCDEF1, "R2", "R4");
    run_op(0, -12'sd16, 32'h00017FFF, "R2", "R4");
    // R8: saturation
    run_op(0, 12'd100,  32'hFFFFFFFF, "R8", "R4");
    run_op(0, 12'h800,  32'hFFFF0001, "R8", "R4");
    // R5 R6: rotates
    run_op(1, 12'd3,    32'h00000005, "R5", "R6");
    run_op(1, -12'sd5,  32'hF8000001, "R5", "R6");
    run_op(1, 12'd16,   32'hABCD1234, "R5", "R6");
    run_op(1, -12'sd1,  32'h80000000, "R5", "R6");
    run_op(1, 12'd0,    32'h87654321, "R6", "R6");
    run_op(1, -12'sd300, 32'hC0000003, "R8", "R6");

    // R7: start while busy is dropped
    cur_tag = "R7"; done_tag = "R7";
    drive(1, 1, 12'd8, 32'h0000_00FF);
    drive(1, 0, -12'sd3, 32'h1111_1111);
    drive(1, 1, 12'd2, 32'h2222_2222);
    repeat (4) drive(0, 0, 12'h000, 32'h0);
    drive(1, 0, 12'd1, 32'h3333_3333);
    repeat (5) drive(0, 0, 12'h000, 32'h0);

    // R9: back-to-back shifts, start on the done cycle of a rotate
    cur_tag = "R9"; done_tag = "R9";
    drive(1, 0, 12'd2, 32'hAAAA_5555);
    drive(1, 0, -12'sd2, 32'hC000_0001);
    drive(1, 1, 12'd2, 32'h0000_0003);
    drive(0, 0, 12'h000, 32'h0);
    drive(1, 0, 12'd4, 32'h0F00_0000);
    repeat (4) drive(0, 0, 12'h000, 32'h0);

    // R1: reset mid-operation clears the outputs
    cur_tag = "R1"; done_tag = "R1";
    drive(1, 1, 12'd10, 32'h1234_5678);
    drive(0, 0, 12'h000, 32'h0);
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) drive(0, 0, 12'h000, 32'h0);
    run_op(0, -12'sd8, 32'hFF00_00FF, "R2", "R4");

    @(negedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule